// File: doc/BRIEF.md
# Fractionally Spaced Decimating Receive Equalizer

This block is the linear equalizer of a serial receiver. It takes digitized samples of the received waveform, several per unit interval (UI), and runs them through a finite impulse response filter. The filter's taps are spaced one sample apart, and together they cover a window of three UIs ahead of the main cursor, the main UI itself, and five UIs after it. The filter result is kept for only one sample slot in each UI. That slot is chosen by a phase select input. The kept value is rounded and saturated, and it leaves the block together with its sign, which serves as the detected bit.

The tap weights are computed elsewhere, typically from a measured channel response and a target response, and are written in one at a time. The filter removes intersymbol interference only at the chosen detection phase. The values between those points are never output.

Top module: `fse_rx_eq`

## Requirements
- R1: After reset, eqOut is 0, eqValid is 0, bitOut is 0, and every tap coefficient is 0.
- R2: A write with coefWrEn high stores coefData as the weight of tap coefAddr. Tap k multiplies the sample accepted k samples before the newest one, so tap 0 weights the newest sample. A write with coefAddr at or above the tap count (SPU*9, 36 by default) is ignored.
- R3: eqValid stays low until SPU*9 samples have been accepted since reset.
- R4: Accepted samples are numbered in slots 0 to SPU-1, and the count wraps. The first sample after reset is in slot 0. A result is produced only for a sample whose slot equals phaseSel at the moment it is accepted, so a fixed phaseSel gives one result per UI.
- R5: A sample is accepted on a rising clock edge while sampleValid is high. If that sample produces a result, eqValid pulses high for one cycle, starting at the next rising edge.
- R6: eqOut is the sum over all taps of sample times coefficient, divided by 256 with rounding half toward positive infinity, then saturated to the signed 12-bit range -2048 to 2047. A coefficient of 256 is unity gain.
- R7: bitOut, updated together with eqValid, is 1 when the rounded sum is zero or positive and 0 when it is negative.
- R8: While sampleValid is low, the delay line holds its contents, the slot count does not advance, and no result is produced.
- R9: eqOut and bitOut keep their last values while eqValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 8 | Signed input sample |
| sampleValid | input | 1 | sampleIn is accepted on this edge |
| coefWrEn | input | 1 | Coefficient write enable |
| coefAddr | input | 6 | Tap index to write |
| coefData | input | 10 | Signed coefficient, 256 means unity |
| phaseSel | input | 2 | Sample slot kept for detection |
| eqOut | output | 12 | Rounded, saturated equalizer output |
| eqValid | output | 1 | One-cycle strobe for a new eqOut |
| bitOut | output | 1 | Sliced bit, 1 for non-negative output |

## Verification
Suppose a sample is accepted on clock edge E and falls in the selected slot. Its result then appears on eqValid, eqOut and bitOut after edge E+1, which is one edge for the slot decision and the delay line, and one edge for the multiply-accumulate register. When the driver task presents such a sample, it stores the expected value and the cycle number E+1 in the scoreboard queue. The monitor looks at the outputs only on falling edges. It checks that each strobe arrives in exactly the recorded cycle, and it treats any strobe with nothing queued as a failure. Coefficient and phase changes are made only after the queue has drained, so every expected value depends on a single, known set of coefficients.

// File: rtl/fse_rx_pkg.sv
package fse_rx_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic shift;   // advance the sample delay line this edge
    logic decim;   // capture the filter sum this edge
  } eqStrobe_t;
endpackage

// File: rtl/fse_rx_ctrl.sv
module fse_rx_ctrl #(
  parameter int SPU  = 4,
  parameter int TAPS = 36,
  parameter int PH_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleValid,
  input  logic [PH_W-1:0]        phaseSel,
  output fse_rx_pkg::eqStrobe_t  strobe
);
  localparam int FILL_W = $clog2(TAPS + 1);

  logic [PH_W-1:0]   slotQ;
  logic [FILL_W-1:0] fillQ;
  logic              decimQ;
  logic              fillDone;

  // Slot counter: one variant per parameter choice
  generate
    if (SPU > 1) begin : g_slot
      logic lastSlot;
      assign lastSlot = (slotQ == PH_W'(SPU - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotQ <= '0;
        end else if (sampleValid) begin
          slotQ <= lastSlot ? '0 : slotQ + 1'b1;
        end
      end
    end else begin : g_single
      assign slotQ = '0;
    end
  endgenerate

  // The sample being accepted is the TAPS-th or later
  assign fillDone = (fillQ >= FILL_W'(TAPS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillQ  <= '0;
      decimQ <= 1'b0;
    end else begin
      decimQ <= sampleValid && fillDone && (slotQ == phaseSel);
      if (sampleValid && (fillQ != FILL_W'(TAPS))) begin
        fillQ <= fillQ + 1'b1;
      end
    end
  end

  assign strobe.shift = sampleValid;
  assign strobe.decim = decimQ;

  // R3: a decimation strobe only after the delay line is full
  a_r3_fill_before_decim: assert property (@(posedge clk) disable iff (!rstN)
    decimQ |-> (fillQ == FILL_W'(TAPS)));

endmodule

// File: rtl/fse_rx_datapath.sv
module fse_rx_datapath #(
  parameter int TAPS   = 36,
  parameter int SAMP_W = 8,
  parameter int COEF_W = 10,
  parameter int OUT_W  = 12,
  parameter int FRAC_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fse_rx_pkg::eqStrobe_t        strobe,
  input  logic signed [SAMP_W-1:0]     sampleIn,
  input  logic                         coefWrEn,
  input  logic        [ADDR_W-1:0]     coefAddr,
  input  logic signed [COEF_W-1:0]     coefData,
  output logic signed [OUT_W-1:0]      eqOut,
  output logic                         eqValid,
  output logic                         bitOut
);
  localparam int PROD_W = SAMP_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(TAPS);
  localparam int RND_W  = ACC_W + 1;
  localparam logic signed [RND_W-1:0] HALF_LSB = RND_W'(2 ** (FRAC_W - 1));
  localparam logic signed [RND_W-1:0] OUT_MAX  = RND_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [RND_W-1:0] OUT_MIN  = -RND_W'(2 ** (OUT_W - 1));

  logic signed [SAMP_W-1:0] lineQ [TAPS];
  logic signed [COEF_W-1:0] coefQ [TAPS];
  logic signed [ACC_W-1:0]  accSum;
  logic signed [RND_W-1:0]  biased;
  logic signed [RND_W-1:0]  shifted;
  logic signed [OUT_W-1:0]  satVal;
  logic signed [OUT_W-1:0]  eqOutQ;
  logic                     eqValidQ;
  logic                     bitQ;

  // Sample delay line, tap 0 holds the newest sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) lineQ[k] <= '0;
    end else if (strobe.shift) begin
      lineQ[0] <= sampleIn;
      for (int k = 1; k < TAPS; k++) lineQ[k] <= lineQ[k-1];
    end
  end

  // Coefficient bank; addresses past the last tap match nothing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) coefQ[k] <= '0;
    end else if (coefWrEn) begin
      for (int k = 0; k < TAPS; k++) begin
        if (coefAddr == ADDR_W'(k)) coefQ[k] <= coefData;
      end
    end
  end

  // Full-width multiply-accumulate across all taps
  always_comb begin
    logic signed [PROD_W-1:0] prod;
    accSum = '0;
    for (int k = 0; k < TAPS; k++) begin
      prod   = lineQ[k] * coefQ[k];
      accSum = accSum + ACC_W'(prod);
    end
  end

  // Round half up, then clamp to the output range
  always_comb begin
    biased  = RND_W'(accSum) + HALF_LSB;
    shifted = biased >>> FRAC_W;
    if (shifted > OUT_MAX)      satVal = OUT_MAX[OUT_W-1:0];
    else if (shifted < OUT_MIN) satVal = OUT_MIN[OUT_W-1:0];
    else                        satVal = shifted[OUT_W-1:0];
  end

  // Decimation register and sign slicer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eqOutQ   <= '0;
      eqValidQ <= 1'b0;
      bitQ     <= 1'b0;
    end else begin
      eqValidQ <= strobe.decim;
      if (strobe.decim) begin
        eqOutQ <= satVal;
        bitQ   <= !shifted[RND_W-1];
      end
    end
  end

  assign eqOut   = eqOutQ;
  assign eqValid = eqValidQ;
  assign bitOut  = bitQ;

  // R7: the sliced bit agrees with the sign of the saturated output
  a_r7_slicer_sign: assert property (@(posedge clk) disable iff (!rstN)
    eqValidQ |-> (bitQ == !eqOutQ[OUT_W-1]));

  // R9: outputs hold between strobes
  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !eqValidQ |-> ($stable(eqOutQ) && $stable(bitQ)));

  // R8: the delay line is frozen on edges without a sample
  a_r8_line_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> ($stable(lineQ[0]) && $stable(lineQ[TAPS-1])));

endmodule

// File: rtl/fse_rx_eq.sv
module fse_rx_eq #(
  parameter int SPU     = 4,
  parameter int PRE_UI  = 3,
  parameter int POST_UI = 5,
  parameter int SAMP_W  = 8,
  parameter int COEF_W  = 10,
  parameter int OUT_W   = 12,
  parameter int FRAC_W  = 8,
  localparam int TAPS   = SPU * (PRE_UI + 1 + POST_UI),
  localparam int ADDR_W = $clog2(TAPS),
  localparam int PH_W   = (SPU > 1) ? $clog2(SPU) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [SAMP_W-1:0] sampleIn,
  input  logic                     sampleValid,
  input  logic                     coefWrEn,
  input  logic        [ADDR_W-1:0] coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  input  logic        [PH_W-1:0]   phaseSel,
  output logic signed [OUT_W-1:0]  eqOut,
  output logic                     eqValid,
  output logic                     bitOut
);
  fse_rx_pkg::eqStrobe_t strobe;

  fse_rx_ctrl #(
    .SPU  (SPU),
    .TAPS (TAPS),
    .PH_W (PH_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .phaseSel    (phaseSel),
    .strobe      (strobe)
  );

  fse_rx_datapath #(
    .TAPS   (TAPS),
    .SAMP_W (SAMP_W),
    .COEF_W (COEF_W),
    .OUT_W  (OUT_W),
    .FRAC_W (FRAC_W),
    .ADDR_W (ADDR_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sampleIn (sampleIn),
    .coefWrEn (coefWrEn),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .eqOut    (eqOut),
    .eqValid  (eqValid),
    .bitOut   (bitOut)
  );

  // R5: every result strobe traces back to a sample taken two edges earlier
  a_r5_valid_after_sample: assert property (@(posedge clk) disable iff (!rstN)
    eqValid |-> $past(sampleValid, 2));

endmodule

// File: tb/fse_rx_eq_bench.sv
`timescale 1ns/1ps
module fse_rx_eq_bench;
  localparam int SPU  = 4;
  localparam int TAPS = SPU * 9;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic signed [7:0] sampleIn = '0;
  logic              sampleValid = 1'b0;
  logic              coefWrEn = 1'b0;
  logic [5:0]        coefAddr = '0;
  logic signed [9:0] coefData = '0;
  logic [1:0]        phaseSel = '0;
  logic signed [11:0] eqOut;
  logic              eqValid;
  logic              bitOut;

  fse_rx_eq u_fse_rx_eq (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .coefWrEn(coefWrEn), .coefAddr(coefAddr), .coefData(coefData),
    .phaseSel(phaseSel), .eqOut(eqOut), .eqValid(eqValid), .bitOut(bitOut)
  );

  always #2.5 clk = ~clk;

  typedef struct { int val; int bitv; int due; } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int failures = 0;
  int cycleCnt = 0;
  int validCnt = 0;
  int lastOut = 0;
  int lastBit = 0;
  bit finished = 0;

  // Reference model state
  int mLine[TAPS];
  int mCoef[TAPS];
  int mFill = 0;
  int mSlot = 0;
  int mPhase = 0;
  int lcg = 12345;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t model_result(int due);
    exp_t e;
    int acc = 0;
    int r;
    for (int k = 0; k < TAPS; k++) acc += mLine[k] * mCoef[k];
    r = (acc + 128) >>> 8;
    e.bitv = (r >= 0) ? 1 : 0;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    e.val = r;
    e.due = due;
    return e;
  endfunction

  // Driver: present one sample and queue the expected result
  task automatic send_sample(int x);
    @(negedge clk);
    coefWrEn = 1'b0;
    sampleValid = 1'b1;
    sampleIn = 8'(x);
    for (int k = TAPS - 1; k > 0; k--) mLine[k] = mLine[k-1];
    mLine[0] = x;
    if (mFill >= TAPS - 1 && mSlot == mPhase) expQ.push_back(model_result(cycleCnt + 2));
    if (mFill < TAPS) mFill++;
    mSlot = (mSlot + 1) % SPU;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b0;
      coefWrEn = 1'b0;
    end
  endtask

  task automatic write_coef(int addr, int val);
    @(negedge clk);
    sampleValid = 1'b0;
    coefWrEn = 1'b1;
    coefAddr = 6'(addr);
    coefData = 10'(val);
    if (addr < TAPS) mCoef[addr] = val;
    @(negedge clk);
    coefWrEn = 1'b0;
  endtask

  task automatic set_phase(int p);
    @(negedge clk);
    sampleValid = 1'b0;
    phaseSel = 2'(p);
    mPhase = p;
  endtask

  task automatic clear_coefs();
    for (int k = 0; k < TAPS; k++) write_coef(k, 0);
  endtask

  function automatic int next_rand();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return ((lcg >>> 8) % 256) - 128;
  endfunction

  // Monitor: compare each result strobe against the queue
  always @(negedge clk) begin
    if (rstN && eqValid) begin
      exp_t e;
      validCnt++;
      lastOut = eqOut;
      lastBit = bitOut;
      if (expQ.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R4 unexpected eqValid actual=1 expected=0 at cycle %0d", cycleCnt);
      end else begin
        e = expQ.pop_front();
        chk("R5", "strobe cycle", cycleCnt, e.due);
        chk("R6", "eqOut", int'(eqOut), e.val);
        chk("R7", "bitOut", int'(bitOut), e.bitv);
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycleCnt);
    report();
    $finish;
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin mLine[k] = 0; mCoef[k] = 0; end
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "eqOut in reset", int'(eqOut), 0);
    chk("R1", "eqValid in reset", int'(eqValid), 0);
    chk("R1", "bitOut in reset", int'(bitOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R3: 35 samples produce no strobe
    for (int i = 0; i < TAPS - 1; i++) send_sample(i * 3 - 50);
    idle(3);
    chk("R3", "strobes before fill", validCnt, 0);
    // R1: coefficients reset to zero give zero output once filled
    for (int i = 0; i < 9; i++) send_sample(100 - i * 20);
    idle(3);
    chk("R1", "strobes after fill", validCnt, 2);

    // R2/R4: unity on tap 0, phase 0 then phase 2
    write_coef(0, 256);
    for (int i = 0; i < 16; i++) send_sample(next_rand());
    idle(3);
    set_phase(2);
    for (int i = 0; i < 16; i++) send_sample(next_rand());
    idle(3);

    // R2: unity on tap 13 delays by 13 samples
    write_coef(0, 0);
    write_coef(13, 256);
    set_phase(1);
    for (int i = 0; i < 24; i++) send_sample(next_rand());
    idle(3);

    // R2: write beyond the last tap is ignored
    write_coef(40, 300);
    write_coef(63, -200);
    for (int i = 0; i < 12; i++) send_sample(next_rand());
    idle(3);

    // R6/R8: all taps weighted, gaps in the sample stream, phase 3
    for (int k = 0; k < TAPS; k++) write_coef(k, ((k * 37) % 200) - 100);
    set_phase(3);
    for (int i = 0; i < 48; i++) begin
      send_sample(next_rand());
      if (i % 3 == 2) idle(2);
    end
    idle(3);

    // R6: saturation both ways
    for (int k = 0; k < TAPS; k++) write_coef(k, 511);
    set_phase(0);
    for (int i = 0; i < 40; i++) send_sample(127);
    for (int i = 0; i < 40; i++) send_sample(-128);
    idle(3);

    // R6/R7: rounding half up with a half-gain tap
    clear_coefs();
    write_coef(0, 128);
    for (int i = 0; i < 16; i++) begin
      case (i % 4)
        0: send_sample(3);
        1: send_sample(-3);
        2: send_sample(1);
        default: send_sample(-1);
      endcase
    end
    set_phase(1);
    for (int i = 0; i < 16; i++) send_sample((i % 2 == 0) ? 5 : -3);
    idle(3);

    // R9: outputs hold while no strobe arrives
    idle(5);
    chk("R9", "eqOut hold", int'(eqOut), lastOut);
    chk("R9", "bitOut hold", int'(bitOut), lastBit);
    chk("R4", "queue drained", expQ.size(), 0);

    report();
    $finish;
  end
endmodule